// File: doc/BRIEF.md
# Segment Access Protection Checker

This block judges a single memory access against a segment descriptor that is already cached. It also forms the linear address of that access. A request carries:

- the offset and the access width in bytes;
- the kind of access: instruction fetch, data read or data write;
- a flag that marks the stack segment register;
- the descriptor attributes: base, limit, code/data type, expand-down or conforming bit, readable/writable bit, present bit, requested and descriptor privilege levels;
- the processor state: current privilege level, protection enable and virtual-8086 mode.

One cycle after a request strobe, the block presents a registered verdict. The verdict holds a fault flag, a fault class (general-protection or stack) and the linear address. Loading descriptors, paging and delivering the exception are left to neighbouring blocks.

The limit rule depends on the segment. Code segments, ordinary data segments and every instruction fetch use an upper-bound rule. Expand-down data segments use a lower-bound rule. The presence, privilege and type rules run only in protected mode with virtual-8086 mode off. In real mode and in virtual-8086 mode only the limit rule is applied.

Top module: `seg_access_guard`

## Requirements
- R1: During synchronous reset, and in the first cycle after it, `rsp_valid`, `rsp_fault`, `rsp_class` and `rsp_linear` are all zero.
- R2: For every cycle in which `req_valid` is high, `rsp_valid` is high exactly one clock later and carries the verdict for that request. A cycle without `req_valid` gives `rsp_valid` low one clock later, and `rsp_fault`, `rsp_class` and `rsp_linear` keep their previous values.
- R3: `rsp_linear` equals `desc_base + req_offset` modulo 2^32, whether or not the access faults.
- R4: The upper-bound rule applies to fetches (`req_kind`=0), to code segments (`desc_exec`=1) and to data segments with `desc_dir`=0. Under it, the access faults when `req_offset + req_size - 1` is greater than `desc_limit`. The sum is formed at 33 bits, so an access that runs past address 2^32-1 faults. `req_size` is 1, 2 or 4.
- R5: A read or write (`req_kind`≠0) to a data segment (`desc_exec`=0) with `desc_dir`=1 faults when `req_offset` is less than `desc_limit`. An offset equal to the limit is allowed.
- R6: The rules R7 to R10 apply only when `prot_en`=1 and `v86_mode`=0. Otherwise the verdict depends on the limit rules alone.
- R7: A descriptor with `desc_present`=0 faults.
- R8: Any access faults when `cur_cpl` > `desc_dpl`. A read or write also faults when `desc_rpl` > `desc_dpl`. A fetch ignores `desc_rpl`.
- R9: A fetch (`req_kind`=0) from a segment with `desc_exec`=0 faults. A read (`req_kind`=1, and also the unused code 3, which is handled as a read) faults when `desc_exec`=1 and `desc_rw`=0.
- R10: A write (`req_kind`=2) faults when `desc_exec`=1. It also faults when `desc_exec`=0 and `desc_rw`=0.
- R11: On a fault, `rsp_class` is 1 (stack fault) when `req_is_stack`=1 and 0 (general-protection) otherwise. Without a fault, `rsp_class` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_offset | input | 32 | Offset within the segment |
| req_size | input | 3 | Access width in bytes (1, 2 or 4) |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_is_stack | input | 1 | Access goes through the stack segment register |
| desc_base | input | 32 | Segment base |
| desc_limit | input | 32 | Segment limit (byte granular) |
| desc_exec | input | 1 | 1 for a code segment |
| desc_dir | input | 1 | Expand-down (data) or conforming (code) bit |
| desc_rw | input | 1 | Readable (code) or writable (data) bit |
| desc_present | input | 1 | Present bit |
| desc_rpl | input | 2 | Requested privilege level of the selector |
| desc_dpl | input | 2 | Descriptor privilege level |
| cur_cpl | input | 2 | Current privilege level |
| prot_en | input | 1 | Protection enabled |
| v86_mode | input | 1 | Virtual-8086 mode active |
| rsp_valid | output | 1 | Verdict strobe |
| rsp_fault | output | 1 | Access faults |
| rsp_class | output | 1 | 1 stack fault, 0 general-protection fault |
| rsp_linear | output | 32 | Linear address |

## Verification
The bench targets the edges of both limit rules:

- **Last byte on the limit.** A design with an off-by-one in the upper-bound compare either rejects an access whose last byte sits exactly on the limit, or accepts the access one byte beyond it.
- **Wrap past 2^32.** The bench issues a 4-byte access near the top of the address space under a full limit. A 32-bit adder wraps the sum and lets this access through.
- **Expand-down boundary.** It probes an offset one below the limit and one equal to it, which catches an inverted or non-strict compare.
- **Mode gating.** Non-present and privilege violations are issued in virtual-8086 and real mode, where a design that ignores the gating reports spurious faults.
- **Fetch-only rules.** A fetch from an expand-down data segment in real mode, and a fetch with a high requested privilege level, expose designs that apply the read/write rules to fetches.
- **Fault class and address.** Stack-register faults must report the stack class. The linear address must stay correct on faulting accesses and on base-plus-offset wrap.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic {
    FLT_GENERAL = 1'b0,
    FLT_STACK   = 1'b1
  } flt_class_e;

  typedef struct packed {
    logic exec;
    logic dir;
    logic rw;
    logic present;
  } desc_attr_t;

endpackage

// File: rtl/seg_limit_unit.sv
module seg_limit_unit #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0] limit,
  input  logic              is_fetch,
  input  logic              exec,
  input  logic              dir,
  output logic              over
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] last_byte;
  logic [EXT_W-1:0] limit_ext;
  logic             expand_down;
  logic             over_upper;
  logic             over_lower;

  // Upper end of the access, one bit wider so a carry out is kept
  assign last_byte   = {1'b0, offset} + EXT_W'(size) - EXT_W'(1);
  assign limit_ext   = {1'b0, limit};
  assign expand_down = !is_fetch && !exec && dir;
  assign over_upper  = last_byte > limit_ext;
  assign over_lower  = offset < limit;
  assign over        = expand_down ? over_lower : over_upper;

endmodule

// File: rtl/seg_rights_unit.sv
module seg_rights_unit
  import seg_guard_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  acc_kind_e         kind,
  input  desc_attr_t        attr,
  input  logic [PRIV_W-1:0] rpl,
  input  logic [PRIV_W-1:0] dpl,
  input  logic [PRIV_W-1:0] cpl,
  input  logic              prot_en,
  input  logic              v86_mode,
  output logic              deny
);
  logic checks_on;
  logic deny_present;
  logic deny_priv;
  logic deny_type;

  assign checks_on    = prot_en && !v86_mode;
  assign deny_present = !attr.present;

  always_comb begin
    deny_priv = cpl > dpl;
    if (kind != KIND_FETCH && rpl > dpl) deny_priv = 1'b1;
  end

  always_comb begin
    unique case (kind)
      KIND_FETCH: deny_type = !attr.exec;
      KIND_WRITE: deny_type = attr.exec || !attr.rw;
      default:    deny_type = attr.exec && !attr.rw;
    endcase
  end

  assign deny = checks_on && (deny_present || deny_priv || deny_type);

endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] linear
);
  // Carry out of the top bit is dropped: arithmetic modulo 2^ADDR_W
  assign linear = base + offset;
endmodule

// File: rtl/seg_access_guard.sv
module seg_access_guard
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3,
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [1:0]        req_kind,
  input  logic              req_is_stack,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [ADDR_W-1:0] desc_limit,
  input  logic              desc_exec,
  input  logic              desc_dir,
  input  logic              desc_rw,
  input  logic              desc_present,
  input  logic [PRIV_W-1:0] desc_rpl,
  input  logic [PRIV_W-1:0] desc_dpl,
  input  logic [PRIV_W-1:0] cur_cpl,
  input  logic              prot_en,
  input  logic              v86_mode,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic              rsp_class,
  output logic [ADDR_W-1:0] rsp_linear
);
  acc_kind_e   kind;
  desc_attr_t  attr;
  logic        lim_over;
  logic        rights_deny;
  logic        fault_d;
  flt_class_e  class_d;
  logic [ADDR_W-1:0] linear_d;

  assign kind = acc_kind_e'(req_kind);
  assign attr = '{exec: desc_exec, dir: desc_dir, rw: desc_rw, present: desc_present};

  seg_limit_unit #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_limit (
    .offset   (req_offset),
    .size     (req_size),
    .limit    (desc_limit),
    .is_fetch (kind == KIND_FETCH),
    .exec     (desc_exec),
    .dir      (desc_dir),
    .over     (lim_over)
  );

  seg_rights_unit #(.PRIV_W(PRIV_W)) u_rights (
    .kind     (kind),
    .attr     (attr),
    .rpl      (desc_rpl),
    .dpl      (desc_dpl),
    .cpl      (cur_cpl),
    .prot_en  (prot_en),
    .v86_mode (v86_mode),
    .deny     (rights_deny)
  );

  seg_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
    .base   (desc_base),
    .offset (req_offset),
    .linear (linear_d)
  );

  assign fault_d = lim_over || rights_deny;
  assign class_d = (fault_d && req_is_stack) ? FLT_STACK : FLT_GENERAL;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_class  <= 1'b0;
      rsp_linear <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault  <= fault_d;
        rsp_class  <= class_d;
        rsp_linear <= linear_d;
      end
    end
  end

endmodule

// File: rtl/seg_access_guard_chk.sv
module seg_access_guard_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3,
  parameter int PRIV_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_offset,
  input logic [SIZE_W-1:0] req_size,
  input logic [1:0]        req_kind,
  input logic              req_is_stack,
  input logic [ADDR_W-1:0] desc_base,
  input logic [ADDR_W-1:0] desc_limit,
  input logic              desc_exec,
  input logic              desc_dir,
  input logic              desc_present,
  input logic [PRIV_W-1:0] desc_dpl,
  input logic [PRIV_W-1:0] cur_cpl,
  input logic              prot_en,
  input logic              v86_mode,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic              rsp_class,
  input logic [ADDR_W-1:0] rsp_linear
);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && $stable(rsp_fault) && $stable(rsp_linear)));

  assert_linear_sum_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_linear == $past(desc_base + req_offset));

  assert_v86_in_limit_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && v86_mode && !desc_dir && req_size == SIZE_W'(1) &&
     req_offset <= desc_limit) |=> !rsp_fault);

  assert_expand_down_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind != 2'd0 && !desc_exec && desc_dir &&
     req_offset < desc_limit) |=> rsp_fault);

  assert_absent_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && prot_en && !v86_mode && !desc_present) |=> rsp_fault);

  assert_cpl_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && prot_en && !v86_mode && cur_cpl > desc_dpl) |=> rsp_fault);

  assert_write_code_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && prot_en && !v86_mode && req_kind == 2'd2 && desc_exec) |=> rsp_fault);

  assert_class_clean_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> !rsp_class);

  assert_class_stack_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_stack && prot_en && !v86_mode && !desc_present) |=> rsp_class);

  always @(posedge clk) begin
    if (rst) begin
      assert_reset_R1: assert (!rsp_valid || $past(rst) == 1'b0);
    end
  end

endmodule

bind seg_access_guard seg_access_guard_chk #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .PRIV_W(PRIV_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_offset   (req_offset),
  .req_size     (req_size),
  .req_kind     (req_kind),
  .req_is_stack (req_is_stack),
  .desc_base    (desc_base),
  .desc_limit   (desc_limit),
  .desc_exec    (desc_exec),
  .desc_dir     (desc_dir),
  .desc_present (desc_present),
  .desc_dpl     (desc_dpl),
  .cur_cpl      (cur_cpl),
  .prot_en      (prot_en),
  .v86_mode     (v86_mode),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_class    (rsp_class),
  .rsp_linear   (rsp_linear)
);

// File: tb/tb_seg_access_guard.sv
module tb_seg_access_guard;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_offset;
  logic [2:0]  req_size;
  logic [1:0]  req_kind;
  logic        req_is_stack;
  logic [31:0] desc_base;
  logic [31:0] desc_limit;
  logic        desc_exec, desc_dir, desc_rw, desc_present;
  logic [1:0]  desc_rpl, desc_dpl, cur_cpl;
  logic        prot_en, v86_mode;
  logic        rsp_valid, rsp_fault, rsp_class;
  logic [31:0] rsp_linear;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic        f;
    logic        c;
    logic [31:0] l;
    string       tag;
  } exp_t;

  exp_t q[$];

  logic        last_f = 1'b0;
  logic        last_c = 1'b0;
  logic [31:0] last_l = '0;

  always #5 clk = ~clk;

  seg_access_guard dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_offset(req_offset),
    .req_size(req_size), .req_kind(req_kind), .req_is_stack(req_is_stack),
    .desc_base(desc_base), .desc_limit(desc_limit), .desc_exec(desc_exec),
    .desc_dir(desc_dir), .desc_rw(desc_rw), .desc_present(desc_present),
    .desc_rpl(desc_rpl), .desc_dpl(desc_dpl), .cur_cpl(cur_cpl),
    .prot_en(prot_en), .v86_mode(v86_mode), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_class(rsp_class), .rsp_linear(rsp_linear)
  );

  task automatic defaults();
    req_offset = 32'h0; req_size = 3'd4; req_kind = 2'd1; req_is_stack = 1'b0;
    desc_base = 32'h0; desc_limit = 32'h0000_FFFF;
    desc_exec = 1'b0; desc_dir = 1'b0; desc_rw = 1'b1; desc_present = 1'b1;
    desc_rpl = 2'd0; desc_dpl = 2'd0; cur_cpl = 2'd0;
    prot_en = 1'b0; v86_mode = 1'b0;
  endtask

  // Driver: called just after a falling edge; pushes the expected verdict
  task automatic go(input string tag, input logic exp_fault);
    exp_t e;
    e.f = exp_fault;
    e.c = exp_fault & req_is_stack;
    e.l = desc_base + req_offset;
    e.tag = tag;
    q.push_back(e);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: samples 3 ns after the rising edge
  always @(posedge clk) begin
    #3;
    if (!rst && !done) begin
      if (rsp_valid) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R2: unexpected rsp_valid, actual 1 expected 0");
        end else begin
          exp_t e;
          e = q.pop_front();
          if (rsp_fault !== e.f || rsp_class !== e.c || rsp_linear !== e.l) begin
            errors++;
            $display("FAIL %s: actual fault=%0b class=%0b lin=%h expected fault=%0b class=%0b lin=%h",
                     e.tag, rsp_fault, rsp_class, rsp_linear, e.f, e.c, e.l);
          end
        end
        last_f = rsp_fault; last_c = rsp_class; last_l = rsp_linear;
      end else begin
        checks++;
        if (rsp_fault !== last_f || rsp_class !== last_c || rsp_linear !== last_l) begin
          errors++;
          $display("FAIL R2: idle hold actual fault=%0b class=%0b lin=%h expected fault=%0b class=%0b lin=%h",
                   rsp_fault, rsp_class, rsp_linear, last_f, last_c, last_l);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checks++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0 || rsp_class !== 1'b0 || rsp_linear !== 32'h0) begin
      errors++;
      $display("FAIL R1: actual v=%0b f=%0b c=%0b lin=%h expected all zero",
               rsp_valid, rsp_fault, rsp_class, rsp_linear);
    end

    // R3 real-mode read, linear = base + offset
    defaults(); desc_base = 32'h0001_2340; req_offset = 32'h10;
    go("R3 real read", 1'b0);
    // R4 last byte on the limit, then one past
    req_offset = 32'h0000_FFFC; go("R4 at limit", 1'b0);
    req_offset = 32'h0000_FFFD; go("R4 past limit", 1'b1);
    @(negedge clk);
    // R4 wrap past 2^32 under full limit
    defaults(); desc_limit = 32'hFFFF_FFFF; req_offset = 32'hFFFF_FFFE;
    go("R4 33-bit wrap", 1'b1);
    req_offset = 32'hFFFF_FFFC; go("R4 top ok", 1'b0);
    // R3 linear wrap modulo 2^32
    desc_base = 32'hFFFF_0000; req_offset = 32'h0002_0000; go("R3 linear wrap", 1'b0);
    // R5 expand-down
    defaults(); desc_dir = 1'b1; desc_limit = 32'h1000; req_offset = 32'h0FFF;
    go("R5 below limit", 1'b1);
    req_offset = 32'h1000; go("R5 equal limit", 1'b0);
    req_is_stack = 1'b1; req_offset = 32'h0800; go("R5 R11 stack fault", 1'b1);
    // R4 fetch from expand-down data segment uses the upper bound
    req_is_stack = 1'b0; req_kind = 2'd0; req_size = 3'd1; req_offset = 32'h0FFF;
    go("R4 fetch expand-down", 1'b0);
    @(negedge clk);
    // R7 not present in protected mode; R11 classes
    defaults(); prot_en = 1'b1; desc_present = 1'b0; go("R7 absent", 1'b1);
    req_is_stack = 1'b1; go("R7 R11 absent stack", 1'b1);
    // R6 same in virtual-8086 and real mode: no fault
    v86_mode = 1'b1; go("R6 v86 absent", 1'b0);
    v86_mode = 1'b0; prot_en = 1'b0; cur_cpl = 2'd3; go("R6 real cpl", 1'b0);
    // R8 privilege
    defaults(); prot_en = 1'b1; desc_exec = 1'b1; desc_dpl = 2'd2; cur_cpl = 2'd3;
    req_kind = 2'd0; go("R8 cpl>dpl fetch", 1'b1);
    cur_cpl = 2'd0; desc_rpl = 2'd3; go("R8 rpl fetch ok", 1'b0);
    req_kind = 2'd1; go("R8 rpl read", 1'b1);
    desc_rpl = 2'd2; go("R8 rpl equal ok", 1'b0);
    // R9 fetch and read types
    defaults(); prot_en = 1'b1; req_kind = 2'd0; go("R9 fetch data", 1'b1);
    desc_exec = 1'b1; desc_rw = 1'b0; req_kind = 2'd1; go("R9 read execonly", 1'b1);
    req_kind = 2'd3; go("R9 kind3 as read", 1'b1);
    desc_rw = 1'b1; req_kind = 2'd1; go("R9 read code ok", 1'b0);
    // R10 writes
    req_kind = 2'd2; go("R10 write code", 1'b1);
    desc_exec = 1'b0; desc_rw = 1'b0; go("R10 write ro data", 1'b1);
    desc_rw = 1'b1; req_is_stack = 1'b1; go("R10 write rw ok", 1'b0);
    // R3 linear on a faulting access
    desc_base = 32'hABCD_0000; req_offset = 32'h0001_FFFF; go("R3 R11 fault linear", 1'b1);

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2: pending responses actual %0d expected 0", q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule